// File: doc/BRIEF.md
# Reconfigurable Bit-Serial Processing Tile

This block is a square tile of sixteen one-bit processing elements (PEs) that share one broadcast instruction. Each PE owns a one-bit-wide local memory, a one-bit temporary register T and a one-bit carry register. The tile can run in one of two arrangements. In mesh mode the PEs form a 4x4 grid, and each PE can take its first operand from itself or from one of its four compass neighbours. Multi-bit arithmetic then runs one bit per cycle through the carry register. In word mode the same sixteen PEs are threaded in a serpentine order into one 16-bit datapath. Carries ripple across all sixteen positions in a single cycle. Operands come from the PE's own memory, from its lower or upper bit neighbour (for shifts), or from a 16-bit broadcast feature bus.

Changing arrangement takes a fixed three-cycle window. During that window the tile refuses instructions. A tile-wide flag register can be raised or lowered at any time. While the flag is low, memory and T writes are blocked, which gives conditional execution across many tiles. Edge ports carry neighbour-tile bits in mesh mode, and the word's end bits in word mode, so that a row of tiles can shift words serially for loading and readout.

Top module: `pe_tile`

## Requirements
- R1: Each PE's ALU performs one of four operations selected by the 2-bit operation code: 0 = add (sum of A, B and carry-in, with carry-out), 1 = invert A, 2 = A AND B, 3 = A OR B. The second operand B is selected by a 2-bit code: 0 = T, 1 = own memory bit, 2 = constant 0, 3 = constant 1. The result is written to the memory bit at the broadcast address when the memory write bit is set, and to T when the T write bit is set.
- R2: In mesh mode (mode 0), the PE at row r, column c has mesh index 4r+c. Its first operand is selected by a 3-bit code: 0 = own memory, 1 = east (c+1), 2 = south (r+1), 3 = west (c-1), 4 = north (r-1). Every memory read uses the single shared address.
- R3: In mesh mode, a neighbour outside the tile reads the matching edge input (north/south indexed by column, east/west indexed by row) only when that side's attach bit is set. The attach bits are: bit 0 north, bit 1 east, bit 2 south, bit 3 west. When the attach bit is clear, the neighbour reads 0.
- R4: In mesh mode, every accepted add instruction loads each PE's carry register with its carry-out. The carry-in is the carry register when the instruction's carry bit is 1, and 0 otherwise. Instructions that are not adds leave the carry registers unchanged.
- R5: In word mode (mode 1), bit position p lies in row p/4. Its column is p%4 for even rows and 3-p%4 for odd rows. An add produces the full 16-bit sum in one cycle, with the instruction's carry bit as the carry-in of position 0, and the result is truncated to 16 bits.
- R6: In word mode, the first-operand code selects: 0 = own memory, 1 = position p-1 (word_lo_i at p=0, giving a left shift), 2 = position p+1 (word_hi_i at p=15, giving a right shift), 3 = bit p of the feature bus.
- R7: A change on mode_req_i while idle raises busy_o for exactly 3 cycles. mode_o takes the new value in the same edge that lowers busy_o. Instructions presented while busy_o is high are ignored.
- R8: The flag register resets to 1. flag_clr_i clears it, and flag_set_i sets it when flag_clr_i is low. While the flag is 0, memory and T writes are suppressed.
- R9: In mesh mode, north_o, south_o, west_o and east_o present the top-row, bottom-row, left-column and right-column memory bits at the current address.
- R10: After reset, all memory, T and carry bits are 0, mode_o is 0 and busy_o is 0.
- R11: word_lo_o and word_hi_o present the memory bits of word positions 0 and 15 at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_req_i | input | 1 | Requested arrangement: 0 mesh, 1 word |
| flag_set_i | input | 1 | Raise the tile flag |
| flag_clr_i | input | 1 | Lower the tile flag (wins over set) |
| ins_valid_i | input | 1 | Instruction present |
| ins_op_i | input | 2 | ALU operation code |
| ins_src_a_i | input | 3 | First operand select |
| ins_src_b_i | input | 2 | Second operand select |
| ins_cin_i | input | 1 | Carry use (mesh) / carry-in of position 0 (word) |
| ins_addr_i | input | AW | Shared memory address |
| ins_mem_we_i | input | 1 | Write result to memory |
| ins_t_we_i | input | 1 | Write result to T |
| fv_i | input | 16 | Feature bus, bit p to word position p |
| attach_i | input | 4 | Neighbour present per side (N,E,S,W = bit 0..3) |
| north_i | input | 4 | Neighbour bits above, per column |
| south_i | input | 4 | Neighbour bits below, per column |
| west_i | input | 4 | Neighbour bits left, per row |
| east_i | input | 4 | Neighbour bits right, per row |
| word_lo_i | input | 1 | Bit entering position 0 on a left shift |
| word_hi_i | input | 1 | Bit entering position 15 on a right shift |
| north_o | output | 4 | Top-row memory bits |
| south_o | output | 4 | Bottom-row memory bits |
| west_o | output | 4 | Left-column memory bits |
| east_o | output | 4 | Right-column memory bits |
| word_lo_o | output | 1 | Memory bit of word position 0 |
| word_hi_o | output | 1 | Memory bit of word position 15 |
| rd_data_o | output | 16 | Memory bits at current address, by mesh index |
| mode_o | output | 1 | Current arrangement |
| busy_o | output | 1 | Arrangement change in progress |

## Verification
The mesh neighbour paths have no port that writes a chosen pattern into memory. The bench therefore uses the feature bus in word mode to store a known word, switches the tile to mesh mode, and reads neighbours from that word. The pattern is mapped through the serpentine order. T cannot be observed directly, so each mesh result is first captured into T and then ORed into a zeroed scratch address, where it can be read. To show that instructions are refused while busy, a write is held valid across the whole switch window, and the bench then confirms that the target address is still zero.

// File: rtl/pe_tile_pkg.sv
package pe_tile_pkg;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int NPE  = ROWS * COLS;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_INV = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // first operand, mesh arrangement
    localparam logic [2:0] SRC_SELF  = 3'd0;
    localparam logic [2:0] SRC_EAST  = 3'd1;
    localparam logic [2:0] SRC_SOUTH = 3'd2;
    localparam logic [2:0] SRC_WEST  = 3'd3;
    localparam logic [2:0] SRC_NORTH = 3'd4;
    // first operand, word arrangement
    localparam logic [2:0] SRC_LOWER = 3'd1;
    localparam logic [2:0] SRC_UPPER = 3'd2;
    localparam logic [2:0] SRC_FV    = 3'd3;

    // second operand
    localparam logic [1:0] OPB_T    = 2'd0;
    localparam logic [1:0] OPB_MEM  = 2'd1;
    localparam logic [1:0] OPB_ZERO = 2'd2;
    localparam logic [1:0] OPB_ONE  = 2'd3;

    // attach bit positions
    localparam int SIDE_N = 0;
    localparam int SIDE_E = 1;
    localparam int SIDE_S = 2;
    localparam int SIDE_W = 3;

    // serpentine position -> mesh index
    function automatic int snake_idx(input int pos);
        int row;
        int k;
        int col;
        row = pos / COLS;
        k   = pos % COLS;
        col = (row % 2 == 0) ? k : (COLS - 1 - k);
        return row * COLS + col;
    endfunction
endpackage

// File: rtl/pe_alu.sv
module pe_alu
    import pe_tile_pkg::*;
#(
    parameter int N = NPE
) (
    input  logic         word_mode_i,
    input  alu_op_e      op_i,
    input  logic         cin_word_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [N-1:0] cin_mesh_i,
    output logic [N-1:0] res_o,
    output logic [N-1:0] cout_o
);
    localparam int IW = $clog2(N);

    always_comb begin
        logic          c;
        logic [IW-1:0] idx;
        res_o  = '0;
        cout_o = '0;
        c      = cin_word_i;
        for (int p = 0; p < N; p++) begin
            idx = word_mode_i ? IW'(snake_idx(p)) : IW'(p);
            if (!word_mode_i) begin
                c = cin_mesh_i[idx];
            end
            unique case (op_i)
                ALU_ADD: begin
                    res_o[idx]  = a_i[idx] ^ b_i[idx] ^ c;
                    cout_o[idx] = (a_i[idx] & b_i[idx]) | (a_i[idx] & c) | (b_i[idx] & c);
                end
                ALU_INV: res_o[idx] = ~a_i[idx];
                ALU_AND: res_o[idx] = a_i[idx] & b_i[idx];
                default: res_o[idx] = a_i[idx] | b_i[idx];
            endcase
            // ripple into the next serpentine position
            c = cout_o[idx];
        end
    end
endmodule

// File: rtl/pe_cell.sv
module pe_cell #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          res_i,
    input  logic          cout_i,
    input  logic          mem_we_i,
    input  logic          t_we_i,
    input  logic          carry_we_i,
    output logic          rd_o,
    output logic          t_o,
    output logic          carry_o
);
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic             t;
        logic             carry;
    } cell_s;

    cell_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mem_we_i) begin
            s_d.mem[addr_i] = res_i;
        end
        if (t_we_i) begin
            s_d.t = res_i;
        end
        if (carry_we_i) begin
            s_d.carry = cout_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_o    = s_q.mem[addr_i];
    assign t_o     = s_q.t;
    assign carry_o = s_q.carry;
endmodule

// File: rtl/pe_cond.sv
module pe_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_req_i,
    input  logic flag_set_i,
    input  logic flag_clr_i,
    output logic mode_o,
    output logic busy_o,
    output logic flag_o
);
    localparam int SWITCH_CYCLES = 3;
    localparam int CW            = $clog2(SWITCH_CYCLES);

    typedef struct packed {
        logic          mode;
        logic          tgt;
        logic          busy;
        logic [CW-1:0] cnt;
        logic          flag;
    } cond_s;

    cond_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flag_clr_i) begin
            s_d.flag = 1'b0;
        end else if (flag_set_i) begin
            s_d.flag = 1'b1;
        end
        if (!s_q.busy) begin
            if (mode_req_i != s_q.mode) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.tgt  = mode_req_i;
            end
        end else if (s_q.cnt == CW'(SWITCH_CYCLES - 1)) begin
            s_d.busy = 1'b0;
            s_d.mode = s_q.tgt;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{mode: 1'b0, tgt: 1'b0, busy: 1'b0, cnt: '0, flag: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o = s_q.mode;
    assign busy_o = s_q.busy;
    assign flag_o = s_q.flag;

    // R7: the switch window never exceeds three cycles
    p_busy_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && $past(s_q.busy) && $past(s_q.busy, 2)) |=> !s_q.busy);
    // R7: the arrangement flips exactly when busy drops
    p_mode_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.busy) |-> (s_q.mode != $past(s_q.mode)));
    p_mode_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(s_q.busy) |-> $stable(s_q.mode));
    // R8: clear dominates, set raises
    p_flag_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_clr_i |=> !s_q.flag);
    p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_set_i && !flag_clr_i) |=> s_q.flag);
endmodule

// File: rtl/pe_tile.sv
module pe_tile
    import pe_tile_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            mode_req_i,
    input  logic            flag_set_i,
    input  logic            flag_clr_i,
    input  logic            ins_valid_i,
    input  logic [1:0]      ins_op_i,
    input  logic [2:0]      ins_src_a_i,
    input  logic [1:0]      ins_src_b_i,
    input  logic            ins_cin_i,
    input  logic [AW-1:0]   ins_addr_i,
    input  logic            ins_mem_we_i,
    input  logic            ins_t_we_i,
    input  logic [NPE-1:0]  fv_i,
    input  logic [3:0]      attach_i,
    input  logic [COLS-1:0] north_i,
    input  logic [COLS-1:0] south_i,
    input  logic [ROWS-1:0] west_i,
    input  logic [ROWS-1:0] east_i,
    input  logic            word_lo_i,
    input  logic            word_hi_i,
    output logic [COLS-1:0] north_o,
    output logic [COLS-1:0] south_o,
    output logic [ROWS-1:0] west_o,
    output logic [ROWS-1:0] east_o,
    output logic            word_lo_o,
    output logic            word_hi_o,
    output logic [NPE-1:0]  rd_data_o,
    output logic            mode_o,
    output logic            busy_o
);
    logic [NPE-1:0] rd, t_all, carry_all;
    logic [NPE-1:0] op_a, op_b, res, cout, cin_mesh;
    logic [NPE-1:0] lo_m, hi_m, fv_m;
    logic           word_mode, busy, flag;
    logic           accept, mem_we, t_we, carry_we;
    alu_op_e        op;

    function automatic logic pick_a(input logic word, input logic [2:0] sel,
                                    input logic self_b, input logic e_b, input logic s_b,
                                    input logic w_b, input logic n_b, input logic lo_b,
                                    input logic hi_b, input logic fv_b);
        logic v;
        v = 1'b0;
        if (word) begin
            case (sel)
                SRC_SELF:  v = self_b;
                SRC_LOWER: v = lo_b;
                SRC_UPPER: v = hi_b;
                SRC_FV:    v = fv_b;
                default:   v = 1'b0;
            endcase
        end else begin
            case (sel)
                SRC_SELF:  v = self_b;
                SRC_EAST:  v = e_b;
                SRC_SOUTH: v = s_b;
                SRC_WEST:  v = w_b;
                SRC_NORTH: v = n_b;
                default:   v = 1'b0;
            endcase
        end
        return v;
    endfunction

    function automatic logic pick_b(input logic [1:0] sel, input logic t_b, input logic m_b);
        logic v;
        case (sel)
            OPB_T:   v = t_b;
            OPB_MEM: v = m_b;
            OPB_ZERO: v = 1'b0;
            default: v = 1'b1;
        endcase
        return v;
    endfunction

    pe_cond u_cond (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_req_i (mode_req_i),
        .flag_set_i (flag_set_i),
        .flag_clr_i (flag_clr_i),
        .mode_o     (word_mode),
        .busy_o     (busy),
        .flag_o     (flag)
    );

    assign op       = alu_op_e'(ins_op_i);
    assign accept   = ins_valid_i & ~busy;
    assign mem_we   = accept & ins_mem_we_i & flag;
    assign t_we     = accept & ins_t_we_i & flag;
    assign carry_we = accept & (op == ALU_ADD);
    assign cin_mesh = {NPE{ins_cin_i}} & carry_all;

    // word-arrangement neighbours, indexed by mesh position of each bit
    for (genvar p = 0; p < NPE; p++) begin : g_pos
        localparam int I = snake_idx(p);
        assign fv_m[I] = fv_i[p];
        if (p == 0) begin : g_lo_edge
            assign lo_m[I] = word_lo_i;
        end else begin : g_lo_in
            assign lo_m[I] = rd[snake_idx(p - 1)];
        end
        if (p == NPE - 1) begin : g_hi_edge
            assign hi_m[I] = word_hi_i;
        end else begin : g_hi_in
            assign hi_m[I] = rd[snake_idx(p + 1)];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int I = r * COLS + c;
            logic e_b, s_b, w_b, n_b;

            if (c < COLS - 1) begin : g_e_in
                assign e_b = rd[I + 1];
            end else begin : g_e_edge
                assign e_b = attach_i[SIDE_E] & east_i[r];
            end
            if (r < ROWS - 1) begin : g_s_in
                assign s_b = rd[I + COLS];
            end else begin : g_s_edge
                assign s_b = attach_i[SIDE_S] & south_i[c];
            end
            if (c > 0) begin : g_w_in
                assign w_b = rd[I - 1];
            end else begin : g_w_edge
                assign w_b = attach_i[SIDE_W] & west_i[r];
            end
            if (r > 0) begin : g_n_in
                assign n_b = rd[I - COLS];
            end else begin : g_n_edge
                assign n_b = attach_i[SIDE_N] & north_i[c];
            end

            assign op_a[I] = pick_a(word_mode, ins_src_a_i, rd[I], e_b, s_b, w_b, n_b,
                                    lo_m[I], hi_m[I], fv_m[I]);
            assign op_b[I] = pick_b(ins_src_b_i, t_all[I], rd[I]);

            pe_cell #(.DEPTH(DEPTH)) u_cell (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .addr_i     (ins_addr_i),
                .res_i      (res[I]),
                .cout_i     (cout[I]),
                .mem_we_i   (mem_we),
                .t_we_i     (t_we),
                .carry_we_i (carry_we),
                .rd_o       (rd[I]),
                .t_o        (t_all[I]),
                .carry_o    (carry_all[I])
            );
        end
    end

    pe_alu #(.N(NPE)) u_alu (
        .word_mode_i (word_mode),
        .op_i        (op),
        .cin_word_i  (ins_cin_i),
        .a_i         (op_a),
        .b_i         (op_b),
        .cin_mesh_i  (cin_mesh),
        .res_o       (res),
        .cout_o      (cout)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_ns_out
        assign north_o[c] = rd[c];
        assign south_o[c] = rd[(ROWS - 1) * COLS + c];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_we_out
        assign west_o[r] = rd[r * COLS];
        assign east_o[r] = rd[r * COLS + COLS - 1];
    end

    assign word_lo_o = rd[snake_idx(0)];
    assign word_hi_o = rd[snake_idx(NPE - 1)];
    assign rd_data_o = rd;
    assign mode_o    = word_mode;
    assign busy_o    = busy;

    // R8: a lowered flag freezes every T register
    p_t_hold_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag |=> $stable(t_all));
    // R7: nothing is executed inside the switch window
    p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |=> ($stable(t_all) && $stable(carry_all)));
    // R4: carry registers move only on accepted adds
    p_carry_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ins_valid_i && !busy && ins_op_i == 2'd0) |=> $stable(carry_all));
endmodule

// File: tb/tb_pe_tile.sv
module tb_pe_tile;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    // encodings as stated in the requirements
    localparam logic [1:0] OP_ADD = 2'd0, OP_INV = 2'd1, OP_AND = 2'd2, OP_OR = 2'd3;
    localparam logic [2:0] A_SELF = 3'd0, A_E = 3'd1, A_S = 3'd2, A_W = 3'd3, A_N = 3'd4;
    localparam logic [2:0] A_LO = 3'd1, A_HI = 3'd2, A_FV = 3'd3;
    localparam logic [1:0] B_T = 2'd0, B_MEM = 2'd1, B_ZERO = 2'd2, B_ONE = 2'd3;

    // word add vectors: {a, b, cin, expected}
    localparam logic [48:0] VEC [0:7] = '{
        {16'h0001, 16'h0001, 1'b0, 16'h0002},
        {16'hFFFF, 16'h0001, 1'b0, 16'h0000},
        {16'h1234, 16'h4321, 1'b0, 16'h5555},
        {16'h00FF, 16'h0000, 1'b1, 16'h0100},
        {16'h8000, 16'h8000, 1'b0, 16'h0000},
        {16'h0F0F, 16'hF0F0, 1'b1, 16'h0000},
        {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF},
        {16'h7FFF, 16'h0001, 1'b0, 16'h8000}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic mode_req, flag_set, flag_clr;
    logic ins_valid, ins_cin, ins_mem_we, ins_t_we;
    logic [1:0] ins_op, ins_src_b;
    logic [2:0] ins_src_a;
    logic [AW-1:0] ins_addr;
    logic [15:0] fv;
    logic [3:0] attach, north_in, south_in, west_in, east_in;
    logic word_lo_in, word_hi_in;
    logic [3:0] north_out, south_out, west_out, east_out;
    logic word_lo_out, word_hi_out;
    logic [15:0] rd_data;
    logic mode_out, busy_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pe_tile #(.DEPTH(DEPTH)) dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode_req),
        .flag_set_i(flag_set), .flag_clr_i(flag_clr),
        .ins_valid_i(ins_valid), .ins_op_i(ins_op), .ins_src_a_i(ins_src_a),
        .ins_src_b_i(ins_src_b), .ins_cin_i(ins_cin), .ins_addr_i(ins_addr),
        .ins_mem_we_i(ins_mem_we), .ins_t_we_i(ins_t_we), .fv_i(fv),
        .attach_i(attach), .north_i(north_in), .south_i(south_in),
        .west_i(west_in), .east_i(east_in), .word_lo_i(word_lo_in),
        .word_hi_i(word_hi_in), .north_o(north_out), .south_o(south_out),
        .west_o(west_out), .east_o(east_out), .word_lo_o(word_lo_out),
        .word_hi_o(word_hi_out), .rd_data_o(rd_data), .mode_o(mode_out),
        .busy_o(busy_out)
    );

    function automatic int pos2idx(input int p);
        int row;
        row = p / 4;
        if (row % 2 == 0) return row * 4 + (p % 4);
        return row * 4 + (3 - p % 4);
    endfunction

    function automatic logic [15:0] to_word(input logic [15:0] m);
        logic [15:0] w;
        for (int p = 0; p < 16; p++) w[p] = m[pos2idx(p)];
        return w;
    endfunction

    function automatic logic [15:0] to_mesh(input logic [15:0] w);
        logic [15:0] m;
        for (int p = 0; p < 16; p++) m[pos2idx(p)] = w[p];
        return m;
    endfunction

    function automatic logic [15:0] mesh_expect(input logic [15:0] m, input logic [2:0] src);
        logic [15:0] e;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                int i;
                i = r * 4 + c;
                case (src)
                    A_E:     e[i] = (c < 3) ? m[i + 1] : (attach[1] & east_in[r]);
                    A_S:     e[i] = (r < 3) ? m[i + 4] : (attach[2] & south_in[c]);
                    A_W:     e[i] = (c > 0) ? m[i - 1] : (attach[3] & west_in[r]);
                    A_N:     e[i] = (r > 0) ? m[i - 4] : (attach[0] & north_in[c]);
                    default: e[i] = m[i];
                endcase
            end
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] a, input logic [1:0] b,
                         input logic cin, input logic [AW-1:0] addr,
                         input logic mwe, input logic twe);
        @(negedge clk);
        ins_op = op; ins_src_a = a; ins_src_b = b; ins_cin = cin;
        ins_addr = addr; ins_mem_we = mwe; ins_t_we = twe; ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] addr, output logic [15:0] v);
        ins_addr = addr;
        #1;
        v = rd_data;
    endtask

    task automatic load_word(input logic [AW-1:0] addr, input logic [15:0] w);
        fv = w;
        issue(OP_OR, A_FV, B_ZERO, 1'b0, addr, 1'b1, 1'b0);
    endtask

    task automatic load_t(input logic [15:0] w);
        fv = w;
        issue(OP_OR, A_FV, B_ZERO, 1'b0, 6'd0, 1'b0, 1'b1);
    endtask

    task automatic switch_mode(input logic m);
        @(negedge clk);
        mode_req = m;
        repeat (5) @(negedge clk);
    endtask

    // run op into T, then OR T into zeroed scratch address 7 and read it
    task automatic mesh_fetch(input logic [1:0] op, input logic [2:0] a, input logic [1:0] b,
                              input logic [AW-1:0] addr, output logic [15:0] v);
        issue(op, a, b, 1'b0, addr, 1'b0, 1'b1);
        issue(OP_OR, A_SELF, B_T, 1'b0, 6'd7, 1'b1, 1'b0);
        peek(6'd7, v);
        issue(OP_AND, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] v, m, w;
        logic busy_seen [1:4];
        logic mode_seen [1:4];
        rst_n = 1'b0; mode_req = 1'b0; flag_set = 1'b0; flag_clr = 1'b0;
        ins_valid = 1'b0; ins_op = 2'd0; ins_src_a = 3'd0; ins_src_b = 2'd0;
        ins_cin = 1'b0; ins_addr = '0; ins_mem_we = 1'b0; ins_t_we = 1'b0;
        fv = '0; attach = '0; north_in = '0; south_in = '0; west_in = '0; east_in = '0;
        word_lo_in = 1'b0; word_hi_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        peek(6'd0, v);
        check("R10 mem", v, 16'h0000);
        check("R10 mode/busy", {14'd0, mode_out, busy_out}, 16'h0000);
        check("R10 edges", {north_out, south_out, west_out, east_out}, 16'h0000);

        // R7: switch to word with a write held valid across the window
        @(negedge clk);
        mode_req = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            #1;
            busy_seen[k] = busy_out;
            mode_seen[k] = mode_out;
            if (k == 1) begin
                fv = 16'hFFFF; ins_op = OP_OR; ins_src_a = A_FV; ins_src_b = B_ZERO;
                ins_addr = 6'd12; ins_mem_we = 1'b1; ins_t_we = 1'b0; ins_valid = 1'b1;
            end
            if (k == 3) ins_valid = 1'b0;
        end
        check("R7 busy window", {12'd0, busy_seen[1], busy_seen[2], busy_seen[3], busy_seen[4]},
              16'h000E);
        check("R7 mode timing", {12'd0, mode_seen[1], mode_seen[2], mode_seen[3], mode_seen[4]},
              16'h0001);
        peek(6'd12, v);
        check("R7 ignored while busy", v, 16'h0000);

        // R5 / R11: table-driven word adds
        for (int n = 0; n < 8; n++) begin
            load_word(6'd1, VEC[n][48:33]);
            load_t(VEC[n][32:17]);
            issue(OP_ADD, A_SELF, B_T, VEC[n][16], 6'd1, 1'b1, 1'b0);
            peek(6'd1, v);
            check("R5 word add", to_word(v), VEC[n][15:0]);
            check("R11 word ends", {14'd0, word_hi_out, word_lo_out},
                  {14'd0, VEC[n][15], VEC[n][0]});
        end

        // R6: shifts through the word edges
        load_word(6'd2, 16'h8421);
        word_lo_in = 1'b1;
        issue(OP_OR, A_LO, B_ZERO, 1'b0, 6'd2, 1'b1, 1'b0);
        peek(6'd2, v);
        check("R6 left shift", to_word(v), 16'h0843);
        word_hi_in = 1'b1;
        issue(OP_OR, A_HI, B_ZERO, 1'b0, 6'd2, 1'b1, 1'b0);
        peek(6'd2, v);
        check("R6 right shift in 1", to_word(v), 16'h8421);
        word_hi_in = 1'b0;
        issue(OP_OR, A_HI, B_ZERO, 1'b0, 6'd2, 1'b1, 1'b0);
        peek(6'd2, v);
        check("R6 right shift in 0", to_word(v), 16'h4210);

        // R8: flag-gated writes
        load_t(16'h00FF);
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        load_word(6'd3, 16'hBEEF);
        load_t(16'hFFFF);
        @(negedge clk); flag_set = 1'b1; @(negedge clk); flag_set = 1'b0;
        peek(6'd3, v);
        check("R8 mem write blocked", to_word(v), 16'h0000);
        issue(OP_OR, A_SELF, B_T, 1'b0, 6'd3, 1'b1, 1'b0);
        peek(6'd3, v);
        check("R8 T write blocked", to_word(v), 16'h00FF);
        load_word(6'd4, 16'hBEEF);
        peek(6'd4, v);
        check("R8 write after set", to_word(v), 16'hBEEF);

        // patterns for mesh tests
        load_word(6'd5, 16'hA5C3);
        load_word(6'd9, 16'hFFFF);
        switch_mode(1'b0);
        check("R7 back to mesh", {15'd0, mode_out}, 16'h0000);
        m = to_mesh(16'hA5C3);

        // R2 / R3: neighbours with detached sides
        north_in = 4'hF; south_in = 4'hF; west_in = 4'hF; east_in = 4'hF; attach = 4'h0;
        mesh_fetch(OP_OR, A_SELF, B_ZERO, 6'd5, v);
        check("R2 self", v, mesh_expect(m, A_SELF));
        mesh_fetch(OP_OR, A_E, B_ZERO, 6'd5, v);
        check("R3 east detached", v, mesh_expect(m, A_E));
        mesh_fetch(OP_OR, A_S, B_ZERO, 6'd5, v);
        check("R3 south detached", v, mesh_expect(m, A_S));
        mesh_fetch(OP_OR, A_W, B_ZERO, 6'd5, v);
        check("R3 west detached", v, mesh_expect(m, A_W));
        mesh_fetch(OP_OR, A_N, B_ZERO, 6'd5, v);
        check("R3 north detached", v, mesh_expect(m, A_N));

        // R2 / R3: neighbours with attached sides
        attach = 4'hF; north_in = 4'b1010; east_in = 4'b0110; south_in = 4'b0011; west_in = 4'b1001;
        mesh_fetch(OP_OR, A_E, B_ZERO, 6'd5, v);
        check("R2 east attached", v, mesh_expect(m, A_E));
        mesh_fetch(OP_OR, A_S, B_ZERO, 6'd5, v);
        check("R2 south attached", v, mesh_expect(m, A_S));
        mesh_fetch(OP_OR, A_W, B_ZERO, 6'd5, v);
        check("R2 west attached", v, mesh_expect(m, A_W));
        mesh_fetch(OP_OR, A_N, B_ZERO, 6'd5, v);
        check("R2 north attached", v, mesh_expect(m, A_N));

        // R9: edge outputs
        peek(6'd5, v);
        check("R9 north/south", {8'd0, north_out, south_out}, {8'd0, m[3:0], m[15:12]});
        check("R9 west/east", {8'd0, west_out, east_out},
              {8'd0, m[12], m[8], m[4], m[0], m[15], m[11], m[7], m[3]});

        // R1: ALU operations
        mesh_fetch(OP_INV, A_SELF, B_ZERO, 6'd5, v);
        check("R1 invert", v, ~m);
        mesh_fetch(OP_AND, A_SELF, B_T, 6'd5, v);
        check("R1 and with T", v, 16'h0000);
        mesh_fetch(OP_AND, A_SELF, B_ONE, 6'd5, v);
        check("R1 and with one", v, m);
        mesh_fetch(OP_OR, A_SELF, B_ONE, 6'd5, v);
        check("R1 or with one", v, 16'hFFFF);
        mesh_fetch(OP_AND, A_SELF, B_MEM, 6'd5, v);
        check("R1 and with own mem", v, m);

        // R4: bit-serial carry
        issue(OP_ADD, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b0, 1'b0);
        issue(OP_ADD, A_SELF, B_ONE, 1'b1, 6'd9, 1'b0, 1'b0);
        issue(OP_ADD, A_SELF, B_ZERO, 1'b1, 6'd7, 1'b1, 1'b0);
        peek(6'd7, v);
        check("R4 carry consumed", v, 16'hFFFF);
        issue(OP_AND, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b1, 1'b0);
        issue(OP_ADD, A_SELF, B_ZERO, 1'b1, 6'd7, 1'b1, 1'b0);
        peek(6'd7, v);
        check("R4 carry cleared by add", v, 16'h0000);
        issue(OP_ADD, A_SELF, B_ONE, 1'b1, 6'd9, 1'b0, 1'b0);
        issue(OP_OR, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b0, 1'b0);
        issue(OP_ADD, A_SELF, B_ZERO, 1'b1, 6'd7, 1'b1, 1'b0);
        peek(6'd7, v);
        check("R4 carry kept over non-add", v, 16'hFFFF);
        issue(OP_AND, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b1, 1'b0);
        issue(OP_ADD, A_SELF, B_ONE, 1'b1, 6'd9, 1'b0, 1'b0);
        issue(OP_ADD, A_SELF, B_ZERO, 1'b0, 6'd7, 1'b1, 1'b0);
        peek(6'd7, v);
        check("R4 carry unused", v, 16'h0000);

        done = 1;
        report();
        $finish;
    end
endmodule